// File: doc/BRIEF.md
# Infrared SIR Codec with Fractional Bit-Rate Divider

This block sits between a UART shifter and an infrared transceiver. A bit-rate generator divides the system clock in two stages. The first stage is a prescaler with four selectable ratios. The second stage is an integer divider of N that can be stretched by a (16−K)/16 fractional part. The generator issues a 16x oversample strobe, and each group of sixteen strobes forms one bit period.

On the transmit side, the UART level is sampled at each bit boundary. A 0 bit becomes a short high pulse lasting either three or one oversample intervals. A 1 bit leaves the infrared output low. On the receive side, the infrared input is watched over each bit period. A pulse longer than one clock turns into a 0 on the recovered level, and the absence of such a pulse turns into a 1.

All inputs are synchronous to `clk`. The configuration inputs are meant to be changed only while `rst_n` is held low. The fractional correction is suppressed in the settings where it would corrupt the pulse timing: the narrow 1/16 pulse, and the fastest prescaler ratio, which is the one used for the highest bit rates. The suppression is reported on a flag output.

Top module: `irda_sir_codec`

The block is built from one bit-rate generator and two state machines.

Transmit machine:
- States: TX_QUIET (line low, previous bit was 1 or nothing sent yet), TX_PULSE (output high), TX_TAIL (output low for the rest of a 0 bit).
- Transitions: at every bit boundary, the machine enters TX_PULSE if `uart_txd` is 0, or TX_QUIET if it is 1. It moves from TX_PULSE to TX_TAIL on the oversample strobe that ends the last pulse interval.

Receive machine:
- States: RX_WAIT (no high level seen yet), RX_HIGH1 (one high cycle seen), RX_SEEN (a qualifying pulse was found).
- Transitions: RX_WAIT goes to RX_HIGH1 on a high input. RX_HIGH1 goes to RX_SEEN on a second consecutive high input, and back to RX_WAIT on a low one. RX_SEEN holds. Every state returns to RX_WAIT at a bit boundary.

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `ir_tx` is 0 and `os_tick` and `bit_tick` are 0.
- R2: `clk_sel` values 0, 1, 2 and 3 give a prescaled period of 4, 16, 64 and 256 clocks. With no fractional correction, `os_tick` pulses for one clock every period×N clocks. A `div_n` of 0 acts as N=1.
- R3: With the correction active, the first 16−K oversample intervals of each bit last N+1 prescaled periods and the remaining K intervals last N. A bit period is therefore period×(16N+16−K) clocks.
- R4: `frac_blocked` equals `frac_en` AND (`pw_sel` = 1 OR `clk_sel` = 0). While it is high, the correction is ignored and the timing follows R2.
- R5: `bit_tick` pulses together with the `os_tick` that ends the sixteenth interval of a bit. That strobe is the bit boundary.
- R6: When `uart_txd` is 0 at a bit boundary, `ir_tx` goes high in the next clock. It stays high for oversample intervals 0 to 2 when `pw_sel` = 0 (3/16), or for interval 0 only when `pw_sel` = 1 (1/16). It then stays low until the next boundary.
- R7: When `uart_txd` is 1 at a bit boundary, `ir_tx` stays low for the whole following bit. Between boundaries, `uart_txd` has no effect.
- R8: In the clock after a bit boundary, `rx_data` becomes 0 if `ir_rx` was high on two consecutive clocks within the bit just ended, and 1 otherwise. A single-clock high on `ir_rx` leaves it 1. `rx_data` changes only then.
- R9: `rx_data` is 1 while in reset and until the first bit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Prescaler ratio select (4, 16, 64, 256) |
| div_n | input | 4 | Integer divisor N (0 acts as 1) |
| frac_en | input | 1 | Enable (16−K)/16 fractional stretch |
| frac_k | input | 4 | Fractional parameter K |
| pw_sel | input | 1 | Pulse width: 0 = 3/16, 1 = 1/16 |
| uart_txd | input | 1 | Serial level from the UART transmitter |
| ir_rx | input | 1 | Pulse input from the infrared receiver |
| ir_tx | output | 1 | Pulse output to the infrared emitter |
| rx_data | output | 1 | Recovered serial level for the UART receiver |
| os_tick | output | 1 | 16x oversample strobe |
| bit_tick | output | 1 | Bit-boundary strobe |
| frac_blocked | output | 1 | Fractional correction requested but suppressed |

## Verification
- A wrong prescaler count or divider count moves `os_tick` within one oversample interval. That at most N+1 prescaled periods.
- A wrong slot index shifts `bit_tick` and the start or length of the `ir_tx` pulse within the same bit.
- A corrupted receive state shows up on `rx_data` in the clock after the next bit boundary.
- The bench mirrors these timings with its own cycle model, so any such slip is caught at the first clock where an output differs.

// File: rtl/irda_codec_pkg.sv
package irda_codec_pkg;

    localparam int unsigned SLOTS  = 16;
    localparam int unsigned SLOT_W = 4;

    // Transmit pulse shaper states
    typedef enum logic [1:0] {
        TX_QUIET = 2'd0,
        TX_PULSE = 2'd1,
        TX_TAIL  = 2'd2
    } tx_state_t;

    // Receive pulse qualifier states
    typedef enum logic [1:0] {
        RX_WAIT  = 2'd0,
        RX_HIGH1 = 2'd1,
        RX_SEEN  = 2'd2
    } rx_state_t;

    // Last oversample interval (inclusive) in which the pulse is high
    function automatic logic [SLOT_W-1:0] pulse_last_slot(input logic narrow);
        return narrow ? SLOT_W'(0) : SLOT_W'(2);
    endfunction

endpackage

// File: rtl/irda_baud_gen.sv
module irda_baud_gen
    import irda_codec_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              frac_en,
    input  logic [SLOT_W-1:0] frac_k,
    input  logic              pw_sel,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [SLOT_W-1:0] slot,
    output logic              frac_blocked
);

    localparam int CNT_W = DIV_W + 1;
    localparam int KW    = SLOT_W + 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_lim;
    logic              pre_tick;
    logic [CNT_W-1:0]  div_cnt;
    logic [CNT_W-1:0]  n_eff;
    logic [CNT_W-1:0]  divisor;
    logic [CNT_W-1:0]  div_last;
    logic [SLOT_W-1:0] slot_q;
    logic              frac_use;
    logic              stretch;

    // Prescaled period is 4 << (2*clk_sel) system clocks
    always_comb pre_lim = PRE_W'((32'd4 << {clk_sel, 1'b0}) - 32'd1);

    assign pre_tick     = (pre_cnt >= pre_lim);
    assign frac_blocked = frac_en && (pw_sel || (clk_sel == 2'd0));
    assign frac_use     = frac_en && !frac_blocked;
    assign stretch      = frac_use &&
                          ({1'b0, slot_q} < (KW'(SLOTS) - {1'b0, frac_k}));
    assign n_eff        = (div_n == '0) ? CNT_W'(1) : {1'b0, div_n};
    assign divisor      = n_eff + CNT_W'(stretch);
    assign div_last     = divisor - CNT_W'(1);
    assign os_tick      = pre_tick && (div_cnt >= div_last);
    assign bit_tick     = os_tick && (slot_q == SLOT_W'(SLOTS - 1));
    assign slot         = slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            slot_q  <= '0;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
            if (pre_tick) begin
                div_cnt <= os_tick ? '0 : div_cnt + 1'b1;
            end
            if (os_tick) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irda_sir_tx.sv
module irda_sir_tx
    import irda_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              pw_sel,
    input  logic              uart_txd,
    output logic              ir_tx
);

    tx_state_t         state_q;
    tx_state_t         state_d;
    logic              boundary;
    logic [SLOT_W-1:0] last_slot;

    assign boundary  = os_tick && (slot == SLOT_W'(SLOTS - 1));
    assign last_slot = pulse_last_slot(pw_sel);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (boundary) begin
            state_d = uart_txd ? TX_QUIET : TX_PULSE;
        end else begin
            unique case (state_q)
                TX_QUIET: state_d = TX_QUIET;
                TX_PULSE: if (os_tick && (slot == last_slot)) state_d = TX_TAIL;
                TX_TAIL:  state_d = TX_TAIL;
                default:  state_d = TX_QUIET;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TX_PULSE: ir_tx = 1'b1;
            TX_QUIET,
            TX_TAIL:  ir_tx = 1'b0;
            default:  ir_tx = 1'b0;
        endcase
    end

endmodule

// File: rtl/irda_sir_rx.sv
module irda_sir_rx
    import irda_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              ir_rx,
    output logic              rx_data
);

    rx_state_t state_q;
    rx_state_t state_d;
    logic      boundary;
    logic      pulse_found;

    assign boundary    = os_tick && (slot == SLOT_W'(SLOTS - 1));
    assign pulse_found = (state_q == RX_SEEN) || ((state_q == RX_HIGH1) && ir_rx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (boundary) begin
            state_d = RX_WAIT;
        end else begin
            unique case (state_q)
                RX_WAIT:  state_d = ir_rx ? RX_HIGH1 : RX_WAIT;
                RX_HIGH1: state_d = ir_rx ? RX_SEEN  : RX_WAIT;
                RX_SEEN:  state_d = RX_SEEN;
                default:  state_d = RX_WAIT;
            endcase
        end
    end

    // Output: one decision per bit, taken at the boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= 1'b1;
        end else if (boundary) begin
            rx_data <= !pulse_found;
        end
    end

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
    import irda_codec_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              frac_en,
    input  logic [SLOT_W-1:0] frac_k,
    input  logic              pw_sel,
    input  logic              uart_txd,
    input  logic              ir_rx,
    output logic              ir_tx,
    output logic              rx_data,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              frac_blocked
);

    logic [SLOT_W-1:0] slot;

    irda_baud_gen #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_baud (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_sel      (clk_sel),
        .div_n        (div_n),
        .frac_en      (frac_en),
        .frac_k       (frac_k),
        .pw_sel       (pw_sel),
        .os_tick      (os_tick),
        .bit_tick     (bit_tick),
        .slot         (slot),
        .frac_blocked (frac_blocked)
    );

    irda_sir_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .slot     (slot),
        .pw_sel   (pw_sel),
        .uart_txd (uart_txd),
        .ir_tx    (ir_tx)
    );

    irda_sir_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .slot    (slot),
        .ir_rx   (ir_rx),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] clk_sel,
    input logic       frac_en,
    input logic       pw_sel,
    input logic       uart_txd,
    input logic       ir_tx,
    input logic       rx_data,
    input logic       os_tick,
    input logic       bit_tick,
    input logic       frac_blocked
);

    // R6
    zero_bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !uart_txd) |=> ir_tx);

    // R7
    one_bit_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && uart_txd) |=> !ir_tx);

    // R5
    bit_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(rx_data));

    // R4
    frac_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_en && (pw_sel || clk_sel == 2'd0)) |-> frac_blocked);

    // R2
    os_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

endmodule

bind irda_sir_codec irda_sir_codec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .frac_en      (frac_en),
    .pw_sel       (pw_sel),
    .uart_txd     (uart_txd),
    .ir_tx        (ir_tx),
    .rx_data      (rx_data),
    .os_tick      (os_tick),
    .bit_tick     (bit_tick),
    .frac_blocked (frac_blocked)
);

// File: tb/irda_sir_codec_bench.sv
module irda_sir_codec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [3:0] div_n = 4'd1;
    logic       frac_en = 1'b0;
    logic [3:0] frac_k = 4'd0;
    logic       pw_sel = 1'b0;
    logic       uart_txd = 1'b1;
    logic       ir_rx = 1'b0;
    logic       ir_tx, rx_data, os_tick, bit_tick, frac_blocked;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  auto_stim = 1'b1;

    always #2 clk = ~clk;

    irda_sir_codec u_irda_sir_codec (
        .clk (clk), .rst_n (rst_n), .clk_sel (clk_sel), .div_n (div_n),
        .frac_en (frac_en), .frac_k (frac_k), .pw_sel (pw_sel),
        .uart_txd (uart_txd), .ir_rx (ir_rx), .ir_tx (ir_tx),
        .rx_data (rx_data), .os_tick (os_tick), .bit_tick (bit_tick),
        .frac_blocked (frac_blocked)
    );

    // ---------------- reference model, built from the requirements ----------
    int unsigned m_pc, m_dc, m_slot, m_rxs;
    bit          m_pulse, m_rx;

    function automatic int unsigned period_of(input logic [1:0] s);
        return 32'd4 << (2 * s);
    endfunction

    function automatic bit blocked_of(input bit fe, input logic [1:0] s, input bit pw);
        return fe && (pw || s == 2'd0);
    endfunction

    function automatic int unsigned n_of(input logic [3:0] n);
        return (n == 4'd0) ? 1 : n;
    endfunction

    function automatic int unsigned divisor_now();
        bit use_f;
        use_f = frac_en && !blocked_of(frac_en, clk_sel, pw_sel);
        return n_of(div_n) + ((use_f && m_slot < 16 - frac_k) ? 1 : 0);
    endfunction

    function automatic bit exp_os();
        return (m_pc >= period_of(clk_sel) - 1) && (m_dc >= divisor_now() - 1);
    endfunction

    function automatic int unsigned bit_len(input logic [1:0] s, input logic [3:0] n,
                                            input bit fe, input logic [3:0] k, input bit pw);
        bit use_f;
        use_f = fe && !blocked_of(fe, s, pw);
        return period_of(s) * (16 * n_of(n) + (use_f ? 16 - k : 0));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_dc = 0; m_slot = 0; m_rxs = 0; m_pulse = 0; m_rx = 1;
        end else begin
            bit os, pre, bnd;
            os  = exp_os();
            pre = (m_pc >= period_of(clk_sel) - 1);
            bnd = os && (m_slot == 15);
            if (bnd) begin
                m_rx  = !((m_rxs == 2) || (m_rxs == 1 && ir_rx));
                m_rxs = 0;
            end else if (m_rxs == 0) m_rxs = ir_rx ? 1 : 0;
            else if (m_rxs == 1)     m_rxs = ir_rx ? 2 : 0;
            if (bnd) m_pulse = !uart_txd;
            else if (m_pulse && os && m_slot == (pw_sel ? 0 : 2)) m_pulse = 0;
            m_pc = pre ? 0 : m_pc + 1;
            if (pre) m_dc = os ? 0 : m_dc + 1;
            if (os) m_slot = (m_slot + 1) % 16;
        end
    end

    // ---------------- checking helpers ---------------------------------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic step();
        bit eo;
        @(negedge clk);
        eo = exp_os();
        chk(os_tick === eo, "R2 R3", "os_tick", int'(os_tick), int'(eo));
        chk(bit_tick === (eo && m_slot == 15), "R5", "bit_tick",
            int'(bit_tick), int'(eo && m_slot == 15));
        chk(ir_tx === m_pulse, "R6 R7", "ir_tx", int'(ir_tx), int'(m_pulse));
        chk(rx_data === m_rx, "R8 R9", "rx_data", int'(rx_data), int'(m_rx));
        if (auto_stim) begin
            if ($urandom % 40 == 0) uart_txd = $urandom % 2;
            if (ir_rx) ir_rx = ($urandom % 3 != 0);
            else       ir_rx = ($urandom % 40 == 0);
        end
    endtask

    task automatic configure(input logic [1:0] s, input logic [3:0] n, input bit fe,
                             input logic [3:0] k, input bit pw);
        rst_n = 1'b0;
        clk_sel = s; div_n = n; frac_en = fe; frac_k = k; pw_sel = pw;
        repeat (3) step();
        chk(ir_tx === 1'b0, "R1", "ir_tx in reset", int'(ir_tx), 0);
        chk(os_tick === 1'b0 && bit_tick === 1'b0, "R1", "ticks in reset",
            int'(os_tick) + int'(bit_tick), 0);
        chk(rx_data === 1'b1, "R9", "rx_data in reset", int'(rx_data), 1);
        chk(frac_blocked === blocked_of(fe, s, pw), "R4", "frac_blocked",
            int'(frac_blocked), int'(blocked_of(fe, s, pw)));
        rst_n = 1'b1;
        step();
        chk(ir_tx === 1'b0 && os_tick === 1'b0, "R1", "first cycle after reset",
            int'(ir_tx) + int'(os_tick), 0);
    endtask

    task automatic wait_bit();
        do step(); while (bit_tick !== 1'b1);
    endtask

    task automatic measure(input int unsigned expv, input string tag);
        int unsigned cnt;
        wait_bit();
        cnt = 0;
        do begin step(); cnt++; end while (bit_tick !== 1'b1);
        chk(cnt == expv, tag, "bit period in clocks", int'(cnt), int'(expv));
    endtask

    task automatic run_cfg(input logic [1:0] s, input logic [3:0] n, input bit fe,
                           input logic [3:0] k, input bit pw, input int bits, input string tag);
        int unsigned bl;
        bl = bit_len(s, n, fe, k, pw);
        configure(s, n, fe, k, pw);
        measure(bl, tag);
        repeat (bits * bl) step();
    endtask

    // ---------------- stimulus -----------------------------------------------
    initial begin
        int unsigned bl;
        int          hi;
        void'($urandom(32'h1DA5_0F1E));

        run_cfg(2'd0, 4'd5, 1'b0, 4'd0, 1'b0, 6, "R2");   // 320 clocks per bit
        run_cfg(2'd1, 4'd3, 1'b1, 4'd5, 1'b0, 6, "R3");   // 944 clocks per bit
        run_cfg(2'd1, 4'd3, 1'b1, 4'd5, 1'b1, 4, "R4");   // blocked by 1/16 width
        run_cfg(2'd0, 4'd2, 1'b1, 4'd0, 1'b0, 8, "R4");   // blocked by fastest ratio
        run_cfg(2'd2, 4'd0, 1'b0, 4'd0, 1'b0, 3, "R2");   // N=0 acts as 1
        run_cfg(2'd3, 4'd1, 1'b0, 4'd0, 1'b1, 1, "R2");   // largest prescale
        run_cfg(2'd1, 4'd1, 1'b1, 4'd15, 1'b0, 6, "R3");  // K=15, one stretched slot

        for (int i = 0; i < 6; i++) begin
            logic [1:0] s;
            logic [3:0] n, k;
            s = $urandom % 2;
            n = 4'(1 + $urandom % 15);
            k = 4'($urandom % 16);
            run_cfg(s, n, $urandom % 2, k, $urandom % 2, 5, "R3");
        end

        // Directed pulse widths and receiver glitch handling
        auto_stim = 1'b0;
        uart_txd = 1'b0; ir_rx = 1'b0;
        configure(2'd0, 4'd2, 1'b0, 4'd0, 1'b0);
        bl = bit_len(2'd0, 4'd2, 1'b0, 4'd0, 1'b0);
        wait_bit();
        hi = 0;
        for (int c = 0; c < int'(bl); c++) begin step(); hi += int'(ir_tx); end
        chk(hi == 24, "R6", "3/16 pulse high clocks", hi, 24);

        pw_sel = 1'b1;
        wait_bit();
        hi = 0;
        for (int c = 0; c < int'(bl); c++) begin step(); hi += int'(ir_tx); end
        chk(hi == 8, "R6", "1/16 pulse high clocks", hi, 8);

        uart_txd = 1'b1;
        wait_bit();
        hi = 0;
        for (int c = 0; c < int'(bl); c++) begin
            if (c == 40) uart_txd = 1'b0;
            if (c == 41) uart_txd = 1'b1;
            step(); hi += int'(ir_tx);
        end
        chk(hi == 0, "R7", "one bit keeps line dark", hi, 0);

        wait_bit();
        repeat (10) step();
        ir_rx = 1'b1; step(); ir_rx = 1'b0;
        wait_bit(); step();
        chk(rx_data === 1'b1, "R8", "single-clock glitch ignored", int'(rx_data), 1);
        repeat (10) step();
        ir_rx = 1'b1; step(); step(); ir_rx = 1'b0;
        wait_bit(); step();
        chk(rx_data === 1'b0, "R8", "two-clock pulse gives 0", int'(rx_data), 0);
        wait_bit(); step();
        chk(rx_data === 1'b1, "R8", "quiet bit gives 1", int'(rx_data), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule